// File: doc/BRIEF.md
# Synchronous Serial Transmitter with Automatic Reload

This block serializes 16-bit words onto a single data output, most significant bit first. Software places a word in a one-entry holding buffer through a write strobe. The word then moves into a shift register, which sends one bit for each bit step. In master mode a bit step is a one-cycle bit-rate enable pulse. In slave mode a bit step is a falling edge of an external transmit clock. That clock is first brought into the system clock domain through a two-flop synchronizer and an edge detector.

The block has two operating styles. In manual mode, a buffered word is loaded only while the transmit enable input is high. If the shifter finishes while the enable is high and no word is waiting, the block raises an underrun flag, which stays set until a status read. In automatic mode, which needs both the auto control bit and the transmit-mode control bit, the block loads every buffered word as soon as the shifter can take it and ignores the enable input. In this mode the underrun flag is never raised, and the output returns to idle when no further word has been written. When the shifter is idle, the output sits high.

Top module: `ssx_autotx`

## Requirements
- R1: After reset, sdo is 1, buf_empty is 1, underrun is 0 and busy is 0.
- R2: A loaded word appears on sdo from bit 15 down to bit 0, one bit per bit step. After the step that ends bit 0, the next word starts or sdo returns to 1.
- R3: In master mode (cfg_slave=0) a bit step is a cycle with bit_tick=1. In slave mode (cfg_slave=1) a bit step is a falling edge of ext_clk, seen after a two-flop synchronizer and one edge-detect stage. The effect on sdo appears three clock cycles after the edge is sampled.
- R4: Automatic mode is active only when cfg_auto=1 and cfg_txmode=1. With only one of the two bits set, the block behaves as in manual mode.
- R5: A write sets the holding buffer full (buf_empty=0) on the next cycle. When the shifter is idle and loading is allowed, the word moves into the shifter one cycle later. On that same edge buf_empty returns to 1 and busy rises.
- R6: In automatic mode, tx_en has no effect on loading.
- R7: When the last bit step of a word passes and no word is buffered (or manual mode has tx_en=0), busy falls and sdo returns to 1.
- R8: The underrun flag never rises while automatic mode is active.
- R9: In slave mode, a word loaded into an idle shifter holds bit 15 on sdo through the first synchronized falling edge and advances only at the second one.
- R10: In manual mode, underrun is set when the last bit step passes with tx_en=1 and no word buffered. A cycle with stat_rd=1 clears it, but a set in the same cycle wins.
- R11: A word buffered while a word is shifting is loaded on the bit step that ends the current word, with no idle bit between the two words.
- R12: In manual mode with tx_en=0, a buffered word stays buffered: busy stays 0 and buf_empty stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | W | Word to transmit |
| stat_rd | input | 1 | Status read; clears the underrun flag |
| cfg_auto | input | 1 | Auto-transmit control bit |
| cfg_txmode | input | 1 | Transmit-mode control bit; automatic mode needs both |
| cfg_slave | input | 1 | 1 selects the external clock as the bit timer |
| tx_en | input | 1 | Manual transmit enable |
| bit_tick | input | 1 | Master-mode bit-rate enable pulse |
| ext_clk | input | 1 | External transmit clock (slave mode) |
| sdo | output | 1 | Serial data out; 1 while idle |
| buf_empty | output | 1 | Holding buffer empty |
| underrun | output | 1 | Manual-mode underrun flag |
| busy | output | 1 | Shifter is sending a word |

## Verification
The shifter position, the first-edge skip and the synchronizer stages can be checked only through sdo, busy and buf_empty. A wrong bit count or a wrong shift shows on sdo at the very next bit step, which is three cycles later in master runs and eight in slave runs. A lost skip flag in slave mode moves every bit of the word one external clock period early, starting at the first falling edge. Errors in the load condition show as a one-cycle difference in buf_empty or busy, or as a wrong underrun flag after the last bit. The reference model tracks all of these outputs on every clock.

// File: rtl/ssx_autotx.sv
module ssx_autotx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         stat_rd,
  input  logic         cfg_auto,
  input  logic         cfg_txmode,
  input  logic         cfg_slave,
  input  logic         tx_en,
  input  logic         bit_tick,
  input  logic         ext_clk,
  output logic         sdo,
  output logic         buf_empty,
  output logic         underrun,
  output logic         busy
);

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  hold_q, shreg;
  logic          hold_full, active, skip, und_q;
  logic [CW-1:0] bitno;
  logic [2:0]    xs;

  logic auto_on, go, fall, step, adv, last_step, load, und_set;

  assign auto_on   = cfg_auto & cfg_txmode;
  assign go        = auto_on | tx_en;
  assign fall      = xs[2] & ~xs[1];
  assign step      = cfg_slave ? fall : bit_tick;
  assign adv       = active & step & ~skip;
  assign last_step = adv & (bitno == LAST);
  assign load      = hold_full & go & (~active | last_step);
  assign und_set   = last_step & ~load & ~auto_on & tx_en;

  assign sdo       = active ? shreg[W-1] : 1'b1;
  assign buf_empty = ~hold_full;
  assign underrun  = und_q;
  assign busy      = active;

  // external clock synchronizer and falling-edge detect
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) xs <= 3'b000;
    else        xs <= {xs[1:0], ext_clk};

  // holding buffer
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else begin
      if (wr_en) hold_q <= wr_data;
      hold_full <= wr_en | (hold_full & ~load);
    end

  // shifter
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg  <= '0;
      bitno  <= '0;
      active <= 1'b0;
      skip   <= 1'b0;
    end else if (load) begin
      shreg  <= hold_q;
      bitno  <= '0;
      active <= 1'b1;
      skip   <= cfg_slave & ~active;
    end else if (last_step) begin
      active <= 1'b0;
    end else if (adv) begin
      shreg  <= {shreg[W-2:0], 1'b0};
      bitno  <= bitno + 1'b1;
    end else if (active & step & skip) begin
      skip   <= 1'b0;
    end

  // underrun flag
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) und_q <= 1'b0;
    else        und_q <= und_set | (und_q & ~stat_rd);

  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sdo);

  a_r2_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && sdo == $past(hold_q[W-1])));

  a_r5_empty_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_en) |=> buf_empty);

  a_r8_no_underrun_auto: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_on && !underrun) |=> !underrun);

  a_r12_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !auto_on && !tx_en) |=> !busy);

  a_r10_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(busy && step && !skip && bitno == LAST)) |=> !underrun);

  a_r9_first_edge_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && skip && cfg_slave) |=> $stable(sdo));

endmodule

// File: tb/test_ssx_autotx.sv
module test_ssx_autotx;
  localparam int W = 16;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, stat_rd = 0, cfg_auto = 0, cfg_txmode = 0, cfg_slave = 0, tx_en = 0;
  logic bit_tick = 0, ext_clk = 0;
  logic [W-1:0] wr_data = '0;
  logic sdo, buf_empty, underrun, busy;

  always #5 clk = ~clk;

  ssx_autotx #(.W(W)) i_ssx_autotx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .stat_rd(stat_rd),
    .cfg_auto(cfg_auto), .cfg_txmode(cfg_txmode), .cfg_slave(cfg_slave), .tx_en(tx_en),
    .bit_tick(bit_tick), .ext_clk(ext_clk), .sdo(sdo), .buf_empty(buf_empty),
    .underrun(underrun), .busy(busy));

  int n_run = 0, n_fail = 0, cyc = 0;
  string phase = "R1 reset";
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // reference model
  bit m_q[$];
  bit [W-1:0] m_hb;
  bit m_full, m_skip, m_und;
  bit d1, d2, d3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q = {}; m_hb = '0; m_full = 0; m_skip = 0; m_und = 0; d1 = 0; d2 = 0; d3 = 0;
    end else begin
      bit fall, stp, go, bsy, fin, ld;
      fall = d3 && !d2;
      d3 = d2; d2 = d1; d1 = ext_clk;
      stp = cfg_slave ? fall : bit_tick;
      go  = (cfg_auto && cfg_txmode) || tx_en;
      bsy = m_q.size() > 0;
      fin = bsy && stp && !m_skip && m_q.size() == 1;
      ld  = m_full && go && (!bsy || fin);
      if (bsy && stp) begin
        if (m_skip) m_skip = 0;
        else void'(m_q.pop_front());
      end
      if (fin && !ld && !(cfg_auto && cfg_txmode) && tx_en) m_und = 1;
      else if (stat_rd) m_und = 0;
      if (ld) begin
        m_q = {};
        for (int i = W - 1; i >= 0; i--) m_q.push_back(m_hb[i]);
        m_skip = cfg_slave && !bsy;
      end
      if (wr_en) begin m_full = 1; m_hb = wr_data; end
      else if (ld) m_full = 0;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk({phase, " sdo"},       sdo,       m_q.size() ? m_q[0] : 1);
      chk({phase, " busy"},      busy,      m_q.size() > 0);
      chk({phase, " buf_empty"}, buf_empty, !m_full);
      chk({phase, " underrun"},  underrun,  m_und);
    end
    if (cyc > 200000 && !done) begin
      done = 1; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // bit-rate pulse and external clock
  bit tick_run = 0, ext_run = 0;
  int tdiv = 0, ediv = 0;
  always @(negedge clk) begin
    if (tick_run) begin tdiv = (tdiv + 1) % 3; bit_tick = (tdiv == 0); end
    else bit_tick = 0;
    if (ext_run) begin ediv = (ediv + 1) % 4; if (ediv == 0) ext_clk = ~ext_clk; end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_stat();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  initial begin
    wait_n(3);
    chk("R1 reset sdo", sdo, 1);
    chk("R1 reset buf_empty", buf_empty, 1);
    chk("R1 reset underrun", underrun, 0);
    chk("R1 reset busy", busy, 0);
    @(negedge clk); rst_n = 1;
    tick_run = 1;

    phase = "R2 R3 master manual";
    tx_en = 1;
    wr(16'hA5C3);
    wait_n(70);
    phase = "R10 underrun";
    chk("R10 underrun set after empty finish", underrun, 1);
    chk("R7 idle after finish", busy, 0);
    rd_stat();
    chk("R10 cleared by status read", underrun, 0);

    phase = "R12 manual disabled";
    tx_en = 0;
    wr(16'h1234);
    wait_n(30);
    chk("R12 no load with tx_en low busy", busy, 0);
    chk("R12 word kept buf_empty", buf_empty, 0);
    tx_en = 1;
    wait_n(3);
    chk("R5 loaded after enable", busy, 1);
    wait_n(60);
    rd_stat();

    phase = "R4 one control bit only";
    tx_en = 0; cfg_auto = 1; cfg_txmode = 0;
    wr(16'h0F0F);
    wait_n(20);
    chk("R4 auto alone does not load", busy, 0);
    phase = "R6 R8 R11 automatic";
    cfg_txmode = 1;
    wait_n(3);
    chk("R6 auto loads with tx_en low", busy, 1);
    wait_n(10);
    wr(16'hC001);
    wait_n(110);
    chk("R8 no underrun in auto", underrun, 0);
    chk("R7 auto idles when empty", busy, 0);
    chk("R11 both words consumed", buf_empty, 1);
    tx_en = 1;
    wr(16'h8001);
    wait_n(70);
    chk("R8 no underrun in auto with tx_en", underrun, 0);

    phase = "R3 R9 slave manual";
    cfg_auto = 0; cfg_txmode = 0;
    tick_run = 0; ext_run = 1; cfg_slave = 1;
    wait_n(5);
    wr(16'hB38E);
    wait_n(160);
    chk("R10 slave underrun", underrun, 1);
    rd_stat();

    phase = "R9 R11 slave automatic";
    cfg_auto = 1; cfg_txmode = 1; tx_en = 0;
    wr(16'h6E19);
    wait_n(20);
    wr(16'hFFFE);
    wait_n(300);
    chk("R8 slave auto no underrun", underrun, 0);
    chk("R7 slave auto idle", busy, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule